// File: doc/BRIEF.md
# Time Base and Decrementer Timer

This block keeps two independent 64-bit time bases, a main one and an alternate one, plus a 32-bit down-counting decrementer. All three advance on a shared timer tick enable. Software reaches each time base through two 32-bit halves. Writing one half replaces that half and leaves the other half as it was. A run input freezes both time bases in place. Counting resumes from the frozen value when run returns high.

The decrementer loses one count per tick. Expiry is the tick that would take the count below zero. On expiry the block latches an exception request, and the counter either wraps to all ones or stays at zero, as chosen by a mode input. Writing a value with the sign bit set over a non-negative count also raises the request at once. The request stays high until it is acknowledged.

Top module: `timebase_decr`

## Requirements
- R1: A write strobe for the lower half of a time base replaces bits 31:0 with `wr_data` and keeps bits 63:32 unchanged on that edge.
- R2: A write strobe for the upper half of a time base replaces bits 63:32 with `wr_data` and keeps bits 31:0 unchanged on that edge. Both strobes together replace both halves.
- R3: The alternate time base has its own strobes and follows R1, R2, R4 and R5. Its contents never change because of main time base traffic, and the main time base never changes because of alternate traffic.
- R4: With `run`=1 and `tick`=1 and no write to it, a time base increases by exactly one, and the carry passes from bit 31 into bit 32. A write on the same edge takes precedence, and no increment happens on that edge.
- R5: With `run`=0, both time bases hold their values whatever `tick` does. When `run` returns to 1, counting continues from the held value. Holding `run` low or high for longer has no further effect.
- R6: The decrementer drops by one on each tick, independent of `run`. With `sat_mode`=0, a tick at a count of 0 is an expiry: the count becomes 0xFFFFFFFF and the request is raised.
- R7: With `sat_mode`=1, a tick at a count of 0 leaves the count at 0. Only the first such tick after the last decrementer write or reset is an expiry.
- R8: A decrementer write whose bit 31 is 1, made while the current count has bit 31 equal to 0, raises the request on that edge. A write of a negative value over a negative count raises nothing.
- R9: The request stays high until `dec_ack` is sampled high. A raise on the same edge as an acknowledge leaves the request high.
- R10: After reset both time bases read 0, the decrementer reads 0xFFFFFFFF and the request is low.
- R11: A decrementer write loads `dec_wdata` exactly, takes precedence over a tick on the same edge, and re-arms the saturating expiry of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer tick enable shared by all counters |
| run | input | 1 | 1 lets both time bases count, 0 freezes them |
| sat_mode | input | 1 | 1 makes the decrementer stop at zero, 0 makes it wrap |
| wr_data | input | 32 | Write data for any time base half |
| tb_wr_lo | input | 1 | Write main time base bits 31:0 |
| tb_wr_hi | input | 1 | Write main time base bits 63:32 |
| atb_wr_lo | input | 1 | Write alternate time base bits 31:0 |
| atb_wr_hi | input | 1 | Write alternate time base bits 63:32 |
| tb_rd_lo | output | 32 | Main time base bits 31:0 |
| tb_rd_hi | output | 32 | Main time base bits 63:32 |
| atb_rd_lo | output | 32 | Alternate time base bits 31:0 |
| atb_rd_hi | output | 32 | Alternate time base bits 63:32 |
| dec_wr | input | 1 | Load the decrementer |
| dec_wdata | input | 32 | Decrementer load value |
| dec_rd | output | 32 | Current decrementer count |
| dec_ack | input | 1 | Clears the exception request |
| dec_irq | output | 1 | Latched decrementer exception request |

## Verification
The bench uses the default build: 32-bit halves, a 32-bit decrementer and the underflow-on-write trigger enabled. Full-width counters can still reach every boundary, because writes place them there directly. Loading the lower half with values just below all ones makes the carry into the upper half happen within a few ticks. Small decrementer loads make both wrapping and saturating expiry happen within a few cycles, and sign-bit loads exercise the write trigger. Random stimulus mixes run, tick, mode, strobes and acknowledges, and is compared each cycle against a bench model built from the requirements.

// File: rtl/tbd_pkg.sv
package tbd_pkg;

   typedef struct packed {
      logic lo;
      logic hi;
   } half_wr_t;

   typedef enum logic [1:0] {
      DEC_HOLD   = 2'd0,
      DEC_LOAD   = 2'd1,
      DEC_STEP   = 2'd2,
      DEC_EXPIRE = 2'd3
   } dec_op_e;

   localparam int unsigned NUM_BASES = 2;

endpackage

// File: rtl/tbd_split_counter.sv
module tbd_split_counter
   import tbd_pkg::*;
#(
   parameter int unsigned HALF_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  half_wr_t          wr,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] rd_lo,
   output logic [HALF_W-1:0] rd_hi
);
   localparam int unsigned FULL_W = 2 * HALF_W;

   logic [FULL_W-1:0] cnt_q;
   logic [HALF_W-1:0] lo_next, hi_next;
   logic              any_wr;

   assign any_wr = wr.lo | wr.hi;

   always_comb begin
      lo_next = wr.lo ? wdata : cnt_q[HALF_W-1:0];
      hi_next = wr.hi ? wdata : cnt_q[FULL_W-1:HALF_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (any_wr) begin
         cnt_q <= {hi_next, lo_next};
      end else if (adv) begin
         cnt_q <= cnt_q + {{(FULL_W-1){1'b0}}, 1'b1};
      end
   end

   assign rd_lo = cnt_q[HALF_W-1:0];
   assign rd_hi = cnt_q[FULL_W-1:HALF_W];

   p_lo_keeps_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.lo && !wr.hi) |=> (rd_hi == $past(rd_hi)));

   p_hi_keeps_lo_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr.hi && !wr.lo) |=> (rd_lo == $past(rd_lo)));

   p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !any_wr) |=> ({rd_hi, rd_lo} == $past({rd_hi, rd_lo}) + 1'b1));

   p_frozen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !any_wr) |=> $stable({rd_hi, rd_lo}));

endmodule

// File: rtl/tbd_decrementer.sv
module tbd_decrementer
   import tbd_pkg::*;
#(
   parameter int unsigned W        = 32,
   parameter bit          UF_TRIG  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         sat_mode,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] value,
   output logic         fire
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam int unsigned  SIGN     = W - 1;

   logic [W-1:0] cnt_q;
   logic         spent_q;
   dec_op_e      op;
   logic         uf_hit;

   always_comb begin
      op = DEC_HOLD;
      if (wr) begin
         op = DEC_LOAD;
      end else if (tick) begin
         if (cnt_q != '0) begin
            op = DEC_STEP;
         end else if (!sat_mode || !spent_q) begin
            op = DEC_EXPIRE;
         end
      end
   end

   generate
      if (UF_TRIG) begin : g_uf_on
         assign uf_hit = wr & wdata[SIGN] & ~cnt_q[SIGN];
      end else begin : g_uf_off
         assign uf_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= ALL_ONES;
         spent_q <= 1'b0;
      end else begin
         unique case (op)
            DEC_LOAD: begin
               cnt_q   <= wdata;
               spent_q <= 1'b0;
            end
            DEC_STEP: cnt_q <= cnt_q - {{(W-1){1'b0}}, 1'b1};
            DEC_EXPIRE: begin
               if (sat_mode) begin
                  cnt_q   <= '0;
                  spent_q <= 1'b1;
               end else begin
                  cnt_q   <= ALL_ONES;
                  spent_q <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   assign value = cnt_q;
   assign fire  = (op == DEC_EXPIRE) | uf_hit;

   p_wrap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr && !sat_mode && value == '0) |=> (value == ALL_ONES));

   p_sat_stays_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr && sat_mode && value == '0) |=> (value == '0));

   p_load_exact_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (value == $past(wdata)));

   generate
      if (UF_TRIG) begin : g_uf_chk
         p_uf_write_fires_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wdata[SIGN] && !value[SIGN]) |-> fire);
      end
   endgenerate

endmodule

// File: rtl/tbd_irq_latch.sv
module tbd_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ack,
   output logic irq
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (set) begin
         irq_q <= 1'b1;
      end else if (ack) begin
         irq_q <= 1'b0;
      end
   end

   assign irq = irq_q;

   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);

   p_irq_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> irq);

endmodule

// File: rtl/timebase_decr.sv
module timebase_decr
   import tbd_pkg::*;
#(
   parameter int unsigned HALF_W  = 32,
   parameter int unsigned DEC_W   = 32,
   parameter bit          UF_TRIG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              run,
   input  logic              sat_mode,
   input  logic [HALF_W-1:0] wr_data,
   input  logic              tb_wr_lo,
   input  logic              tb_wr_hi,
   input  logic              atb_wr_lo,
   input  logic              atb_wr_hi,
   output logic [HALF_W-1:0] tb_rd_lo,
   output logic [HALF_W-1:0] tb_rd_hi,
   output logic [HALF_W-1:0] atb_rd_lo,
   output logic [HALF_W-1:0] atb_rd_hi,
   input  logic              dec_wr,
   input  logic [DEC_W-1:0]  dec_wdata,
   output logic [DEC_W-1:0]  dec_rd,
   input  logic              dec_ack,
   output logic              dec_irq
);
   initial begin
      if (HALF_W < 2) $fatal(1, "HALF_W must be at least 2");
      if (DEC_W < 2)  $fatal(1, "DEC_W must be at least 2");
   end

   logic                                adv;
   half_wr_t [NUM_BASES-1:0]            base_wr;
   logic     [NUM_BASES-1:0][HALF_W-1:0] base_lo;
   logic     [NUM_BASES-1:0][HALF_W-1:0] base_hi;
   logic                                dec_fire;

   assign adv = run & tick;

   always_comb begin
      base_wr[0].lo = tb_wr_lo;
      base_wr[0].hi = tb_wr_hi;
      base_wr[1].lo = atb_wr_lo;
      base_wr[1].hi = atb_wr_hi;
   end

   generate
      for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
         tbd_split_counter #(.HALF_W(HALF_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv),
            .wr    (base_wr[g]),
            .wdata (wr_data),
            .rd_lo (base_lo[g]),
            .rd_hi (base_hi[g])
         );
      end
   endgenerate

   assign tb_rd_lo  = base_lo[0];
   assign tb_rd_hi  = base_hi[0];
   assign atb_rd_lo = base_lo[1];
   assign atb_rd_hi = base_hi[1];

   tbd_decrementer #(.W(DEC_W), .UF_TRIG(UF_TRIG)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .sat_mode (sat_mode),
      .wr       (dec_wr),
      .wdata    (dec_wdata),
      .value    (dec_rd),
      .fire     (dec_fire)
   );

   tbd_irq_latch u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (dec_fire),
      .ack   (dec_ack),
      .irq   (dec_irq)
   );

   p_alt_untouched_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_wr_lo && !atb_wr_lo && !atb_wr_hi && !adv) |=> $stable({atb_rd_hi, atb_rd_lo}));

endmodule

// File: tb/timebase_decr_tb.sv
`timescale 1ns/1ps
module timebase_decr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, run = 1'b0, sat_mode = 1'b0;
   logic [31:0] wr_data = '0;
   logic        tb_wr_lo = 1'b0, tb_wr_hi = 1'b0, atb_wr_lo = 1'b0, atb_wr_hi = 1'b0;
   logic [31:0] tb_rd_lo, tb_rd_hi, atb_rd_lo, atb_rd_hi, dec_rd;
   logic        dec_wr = 1'b0, dec_ack = 1'b0, dec_irq;
   logic [31:0] dec_wdata = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [63:0] m_tb, m_atb;
   logic [31:0] m_dec;
   logic        m_spent, m_irq;

   always #4 clk = ~clk;

   timebase_decr u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .sat_mode(sat_mode),
      .wr_data(wr_data), .tb_wr_lo(tb_wr_lo), .tb_wr_hi(tb_wr_hi),
      .atb_wr_lo(atb_wr_lo), .atb_wr_hi(atb_wr_hi),
      .tb_rd_lo(tb_rd_lo), .tb_rd_hi(tb_rd_hi),
      .atb_rd_lo(atb_rd_lo), .atb_rd_hi(atb_rd_hi),
      .dec_wr(dec_wr), .dec_wdata(dec_wdata), .dec_rd(dec_rd),
      .dec_ack(dec_ack), .dec_irq(dec_irq)
   );

   function automatic logic [63:0] base_next(input logic [63:0] cur, input logic wl,
                                             input logic wh, input logic [31:0] d,
                                             input logic adv);
      logic [63:0] r;
      r = cur;
      if (wl || wh) begin
         if (wl) r[31:0]  = d;
         if (wh) r[63:32] = d;
      end else if (adv) begin
         r = cur + 64'd1;
      end
      return r;
   endfunction

   task automatic model_update();
      logic set;
      set = 1'b0;
      m_tb  = base_next(m_tb,  tb_wr_lo,  tb_wr_hi,  wr_data, run & tick);
      m_atb = base_next(m_atb, atb_wr_lo, atb_wr_hi, wr_data, run & tick);
      if (dec_wr) begin
         if (dec_wdata[31] && !m_dec[31]) set = 1'b1;
         m_dec   = dec_wdata;
         m_spent = 1'b0;
      end else if (tick) begin
         if (m_dec != 0) m_dec = m_dec - 1;
         else if (!sat_mode) begin set = 1'b1; m_dec = 32'hFFFF_FFFF; m_spent = 1'b0; end
         else if (!m_spent) begin set = 1'b1; m_spent = 1'b1; end
      end
      if (set) m_irq = 1'b1;
      else if (dec_ack) m_irq = 1'b0;
   endtask

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check(tag, "tb",  {tb_rd_hi, tb_rd_lo},   m_tb);
      check(tag, "atb", {atb_rd_hi, atb_rd_lo}, m_atb);
      check(tag, "dec", {32'd0, dec_rd},        {32'd0, m_dec});
      check(tag, "irq", {63'd0, dec_irq},       {63'd0, m_irq});
   endtask

   task automatic step(input string tag);
      model_update();
      @(posedge clk);
      @(negedge clk);
      compare_all(tag);
      tb_wr_lo = 0; tb_wr_hi = 0; atb_wr_lo = 0; atb_wr_hi = 0;
      dec_wr = 0; dec_ack = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'd20240611);
      m_tb = '0; m_atb = '0; m_dec = 32'hFFFF_FFFF; m_spent = 0; m_irq = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R10");

      // R1 lower write, R2 upper write
      wr_data = 32'hAAAA_5555; tb_wr_lo = 1; step("R1");
      wr_data = 32'h1234_5678; tb_wr_hi = 1; step("R2");
      wr_data = 32'h0BAD_F00D; tb_wr_lo = 1; tb_wr_hi = 1; step("R2");

      // R4 carry across halves
      wr_data = 32'hFFFF_FFFE; tb_wr_lo = 1; step("R1");
      run = 1; tick = 1;
      for (int i = 0; i < 3; i++) step("R4");
      wr_data = 32'h0000_0100; tb_wr_lo = 1; step("R4");

      // R3 alternate independent
      wr_data = 32'hCAFE_0001; atb_wr_hi = 1; step("R3");
      wr_data = 32'hFFFF_FFFF; atb_wr_lo = 1; step("R3");
      step("R3");

      // R5 freeze and resume
      run = 0;
      for (int i = 0; i < 4; i++) step("R5");
      run = 1; step("R5"); step("R5");
      tick = 0; step("R5");

      // R6 wrap expiry, R9 ack
      run = 0; tick = 1; sat_mode = 0;
      dec_wdata = 32'd2; dec_wr = 1; step("R11");
      for (int i = 0; i < 4; i++) step("R6");
      tick = 0; step("R9"); step("R9");
      dec_ack = 1; step("R9");

      // R7 saturating expiry
      sat_mode = 1; tick = 1;
      dec_wdata = 32'd1; dec_wr = 1; step("R11");
      step("R7"); step("R7");
      dec_ack = 1; step("R7");
      for (int i = 0; i < 3; i++) step("R7");
      dec_wdata = 32'd0; dec_wr = 1; step("R11");
      step("R7");
      dec_ack = 1; tick = 0; step("R9");

      // R8 underflow write
      dec_wdata = 32'd5; dec_wr = 1; step("R11");
      dec_wdata = 32'h8000_0000; dec_wr = 1; step("R8");
      dec_ack = 1; step("R9");
      dec_wdata = 32'h9000_0000; dec_wr = 1; step("R8");

      // R9 set and ack together
      dec_wdata = 32'd3; dec_wr = 1; step("R11");
      dec_wdata = 32'hF000_0000; dec_wr = 1; dec_ack = 1; step("R9");
      dec_ack = 1; step("R9");

      // R11 write beats tick
      tick = 1; dec_wdata = 32'd7; dec_wr = 1; step("R11");

      // constrained random mix
      for (int c = 0; c < 4000; c++) begin
         tick      = ($urandom % 4) != 0;
         run       = ($urandom % 5) != 0;
         sat_mode  = ($urandom % 2) != 0;
         wr_data   = ($urandom % 3 == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom;
         tb_wr_lo  = ($urandom % 16) == 0;
         tb_wr_hi  = ($urandom % 20) == 0;
         atb_wr_lo = ($urandom % 16) == 0;
         atb_wr_hi = ($urandom % 20) == 0;
         dec_wr    = ($urandom % 10) == 0;
         dec_wdata = ($urandom % 4 == 0) ? $urandom : ($urandom % 6);
         dec_ack   = ($urandom % 6) == 0;
         model_update();
         @(posedge clk);
         @(negedge clk);
         check("R4", "tb",  {tb_rd_hi, tb_rd_lo},   m_tb);
         check("R3", "atb", {atb_rd_hi, atb_rd_lo}, m_atb);
         check("R6", "dec", {32'd0, dec_rd},        {32'd0, m_dec});
         check("R9", "irq", {63'd0, dec_irq},       {63'd0, m_irq});
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule